// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block produces the word address that a synchronous burst memory array uses each cycle. A full address is captured when a burst-start strobe is sampled. Two such strobes exist: one from the host processor and one from a memory controller. After a capture, the low address bits step through a group of four words, and each step happens only on a cycle where the advance input is high. The upper address bits stay at the captured value. A burst is optional, because a new address can be captured on any cycle.

An order input picks linear or interleaved stepping. Low selects interleaved, which is also the state after reset. The order in force is captured together with the address, so it stays fixed for the whole burst. The host strobe acts only while the chip-enable input is high. If the host strobe arrives while the chip is disabled and the controller strobe is low, the current burst ends. All outputs are registered and take their new value one clock after the inputs are sampled.

Top module: `burst_addr_gen`

## Requirements
- R1: After a synchronous reset, `addr_out` is 0 and `burst_active` is 0.
- R2: If `host_start` and `chip_en` are high at an edge, then after that edge `addr_out` equals the sampled `addr_in` and `burst_active` is 1.
- R3: If `host_start` is high while `chip_en` is low, the host strobe captures no address. If `ctrl_start` is also low, the burst ends: `burst_active` goes to 0 and `addr_out` keeps its value.
- R4: If `ctrl_start` is high at an edge, `addr_in` is captured whatever the value of `chip_en`, and `burst_active` goes to 1.
- R5: An address capture takes precedence over `advance` in the same cycle. When both strobes qualify, the host strobe wins, and the result is the captured address.
- R6: With `order_linear`=1 captured, the k-th advance gives low bits equal to (loaded low bits + k) mod 4.
- R7: With `order_linear`=0 captured, the k-th advance gives low bits equal to loaded low bits XOR (k mod 4).
- R8: The order is sampled only at a capture. A change on `order_linear` during a burst has no effect on the stepping.
- R9: While a burst is active, a cycle with `advance` low and no strobe holds `addr_out`.
- R10: Advancing never changes `addr_out[AW-1:2]`. After four advances the low bits wrap back to their loaded value.
- R11: While no burst is active, `advance` has no effect on `addr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Qualifies the host strobe |
| host_start | input | 1 | Burst start from the processor side |
| ctrl_start | input | 1 | Burst start from the controller side |
| advance | input | 1 | Steps the burst counter |
| order_linear | input | 1 | 1 selects linear order, 0 selects interleaved |
| addr_in | input | AW | Address to capture |
| addr_out | output | AW | Current word address |
| burst_active | output | 1 | A burst is in progress |

## Verification
A capture and an advance can fall in the same cycle, because a strobe may arrive while `advance` is still high from the burst it replaces. The stimulus table drives exactly that case twice: once with the controller strobe while the chip is disabled, and once with both strobes together. It then checks that the next address is the raw `addr_in` and not a stepped value. A second collision tested is the host strobe while the chip is disabled. It is driven once with the controller strobe low, which must end the burst, and once with the controller strobe high, which must start a new one.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic {
    ORD_INTLV  = 1'b0,
    ORD_LINEAR = 1'b1
  } burst_order_e;
endpackage

// File: rtl/start_arbiter.sv
module start_arbiter (
  input  logic host_start,
  input  logic chip_en,
  input  logic ctrl_start,
  output logic do_load,
  output logic do_stop
);
  logic host_ok;
  always_comb begin
    host_ok = host_start & chip_en;
    // host strobe has priority; both paths capture the same address
    do_load = host_ok | ctrl_start;
    do_stop = host_start & ~chip_en & ~ctrl_start;
  end
endmodule

// File: rtl/low_seq.sv
module low_seq
  import burst_addr_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_load,
  input  logic          do_stop,
  input  logic          advance,
  input  logic          order_linear,
  input  logic [CW-1:0] low_in,
  output logic [CW-1:0] low_out,
  output logic          active
);
  logic [CW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] step_val;
  burst_order_e  mode_q;

  always_comb begin
    cnt_nx   = cnt_q + 1'b1;
    step_val = (mode_q == ORD_LINEAR) ? (base_q + cnt_nx) : (base_q ^ cnt_nx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      cnt_q   <= '0;
      mode_q  <= ORD_INTLV;
      active  <= 1'b0;
      low_out <= '0;
    end else if (do_load) begin
      base_q  <= low_in;
      cnt_q   <= '0;
      mode_q  <= burst_order_e'(order_linear);
      active  <= 1'b1;
      low_out <= low_in;
    end else if (do_stop) begin
      active  <= 1'b0;
    end else if (active && advance) begin
      cnt_q   <= cnt_nx;
      low_out <= step_val;
    end
  end
endmodule

// File: rtl/upper_hold.sv
module upper_hold #(
  parameter int UW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_load,
  input  logic [UW-1:0] up_in,
  output logic [UW-1:0] up_out
);
  always_ff @(posedge clk) begin
    if (rst)          up_out <= '0;
    else if (do_load) up_out <= up_in;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW        = 18,
  parameter int BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_en,
  input  logic          host_start,
  input  logic          ctrl_start,
  input  logic          advance,
  input  logic          order_linear,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          burst_active
);
  localparam int CW = $clog2(BURST_LEN);
  localparam int UW = AW - CW;

  logic          do_load;
  logic          do_stop;
  logic [CW-1:0] low_q;
  logic [UW-1:0] up_q;

  start_arbiter u_arb (
    .host_start (host_start),
    .chip_en    (chip_en),
    .ctrl_start (ctrl_start),
    .do_load    (do_load),
    .do_stop    (do_stop)
  );

  low_seq #(.CW(CW)) u_low (
    .clk          (clk),
    .rst          (rst),
    .do_load      (do_load),
    .do_stop      (do_stop),
    .advance      (advance),
    .order_linear (order_linear),
    .low_in       (addr_in[CW-1:0]),
    .low_out      (low_q),
    .active       (burst_active)
  );

  upper_hold #(.UW(UW)) u_up (
    .clk     (clk),
    .rst     (rst),
    .do_load (do_load),
    .up_in   (addr_in[AW-1:CW]),
    .up_out  (up_q)
  );

  assign addr_out = {up_q, low_q};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW        = 18,
  parameter int BURST_LEN = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          chip_en,
  input logic          host_start,
  input logic          ctrl_start,
  input logic          advance,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic          burst_active
);
  localparam int CW = $clog2(BURST_LEN);

  p_load_host_r2: assert property (@(posedge clk) disable iff (rst)
    (host_start && chip_en) |=> (addr_out == $past(addr_in)) && burst_active);

  p_stop_r3: assert property (@(posedge clk) disable iff (rst)
    (host_start && !chip_en && !ctrl_start) |=> !burst_active && $stable(addr_out));

  p_load_ctrl_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl_start |=> (addr_out == $past(addr_in)) && burst_active);

  p_wait_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!host_start && !ctrl_start && !advance) |=> $stable(addr_out));

  p_upper_fixed_r10: assert property (@(posedge clk) disable iff (rst)
    (!(host_start && chip_en) && !ctrl_start) |=> $stable(addr_out[AW-1:CW]));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!burst_active && !host_start && !ctrl_start) |=> $stable(addr_out) && !burst_active);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (addr_out == '0) && !burst_active);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .BURST_LEN(BURST_LEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .chip_en      (chip_en),
  .host_start   (host_start),
  .ctrl_start   (ctrl_start),
  .advance      (advance),
  .addr_in      (addr_in),
  .addr_out     (addr_out),
  .burst_active (burst_active)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 18;
  localparam int NV = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chip_en = 1'b0;
  logic          host_start = 1'b0;
  logic          ctrl_start = 1'b0;
  logic          advance = 1'b0;
  logic          order_linear = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          burst_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.AW(AW), .BURST_LEN(4)) uut (
    .clk(clk), .rst(rst), .chip_en(chip_en), .host_start(host_start),
    .ctrl_start(ctrl_start), .advance(advance), .order_linear(order_linear),
    .addr_in(addr_in), .addr_out(addr_out), .burst_active(burst_active)
  );

  // {req[4], host, en, ctrl, adv, lin, addr_in[18], exp_addr[18], exp_act}
  localparam logic [45:0] VEC [NV] = '{
    {4'd2,  5'b11001, 18'h12345, 18'h12345, 1'b1}, // R2 host load, linear
    {4'd8,  5'b00010, 18'h3FFFF, 18'h12346, 1'b1}, // R8 mode flip ignored, R6 k=1
    {4'd6,  5'b00011, 18'h00000, 18'h12347, 1'b1}, // R6 k=2
    {4'd9,  5'b00000, 18'h00000, 18'h12347, 1'b1}, // R9 wait state
    {4'd10, 5'b00011, 18'h00000, 18'h12344, 1'b1}, // R10 wrap, upper kept
    {4'd6,  5'b00011, 18'h00000, 18'h12345, 1'b1}, // R6 back to loaded value
    {4'd4,  5'b00110, 18'h2AAAA, 18'h2AAAA, 1'b1}, // R4 ctrl load, en low, adv high (R5)
    {4'd7,  5'b00010, 18'h00000, 18'h2AAAB, 1'b1}, // R7 2^1
    {4'd7,  5'b00010, 18'h00000, 18'h2AAA8, 1'b1}, // R7 2^2
    {4'd7,  5'b00010, 18'h00000, 18'h2AAA9, 1'b1}, // R7 2^3
    {4'd3,  5'b10010, 18'h11111, 18'h2AAA9, 1'b0}, // R3 host while disabled ends burst
    {4'd11, 5'b00010, 18'h00000, 18'h2AAA9, 1'b0}, // R11 advance while idle
    {4'd3,  5'b10100, 18'h0FFFF, 18'h0FFFF, 1'b1}, // R3 disabled host, ctrl loads
    {4'd5,  5'b11111, 18'h00002, 18'h00002, 1'b1}, // R5 both strobes with advance
    {4'd6,  5'b00011, 18'h00000, 18'h00003, 1'b1}  // R6 from base 2
  };

  task automatic check(input int req, input logic [AW-1:0] ea, input logic eact);
    checks++;
    if (addr_out !== ea || burst_active !== eact) begin
      errors++;
      $display("FAIL R%0d addr=%h act=%b expected addr=%h act=%b",
               req, addr_out, burst_active, ea, eact);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(1, '0, 1'b0); // R1 reset state

    for (int i = 0; i < NV; i++) begin
      {host_start, chip_en, ctrl_start, advance, order_linear} = VEC[i][41:37];
      addr_in = VEC[i][36:19];
      @(negedge clk);
      check(int'(VEC[i][45:42]), VEC[i][18:1], VEC[i][0]);
    end

    // R1 reset in the middle of a burst
    {host_start, chip_en, ctrl_start, advance, order_linear} = 5'b00010;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(1, '0, 1'b0);

    // R11 advance right after reset has no effect
    @(negedge clk);
    check(11, '0, 1'b0);

    // R7 interleaved default with base 1: 1,0,3,2,1
    {host_start, chip_en, ctrl_start, advance, order_linear} = 5'b11000;
    addr_in = 18'h00401;
    @(negedge clk);
    check(7, 18'h00401, 1'b1);
    {host_start, chip_en, ctrl_start, advance, order_linear} = 5'b00010;
    @(negedge clk); check(7, 18'h00400, 1'b1);
    @(negedge clk); check(7, 18'h00403, 1'b1);
    @(negedge clk); check(7, 18'h00402, 1'b1);
    @(negedge clk); check(10, 18'h00401, 1'b1); // R10 wrap

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule